// File: doc/BRIEF.md
# Page-Mode PSRAM Controller

This block sits between a synchronous host and an external asynchronous 16-bit pseudo-static RAM. It drives the memory's chip select, output enable, write enable and the two byte-lane strobes, and it presents a 21-bit word address. Write data goes out on a separate output bus that has its own tristate enable. Read data comes back on an input bus. Refresh and all analog pad timing stay inside the memory and the pad ring.

After reset the controller keeps the memory deselected for a power-up interval. The length of that interval is computed from the clock frequency. It then issues one dummy read, which the memory needs before it is treated as idle. Only after that does it accept host work. The host raises `req` with a command and holds it until the one-cycle `ack` pulse. The command is a single-word read, a byte or word write, or a four-word page burst read. Reads return data with an `rvalid` pulse. A page burst returns four pulses in ascending order of address. The first access of the burst is a full random access, and the three that follow use the shorter page wait.

Top module: `psram_ctl`

## Requirements
- R1: After reset is released, `mem_cs_n` stays high for exactly CLK_MHZ*PWRUP_US clock cycles (37500 by default). During reset all memory controls are high, and `ack` and `rvalid` are low.
- R2: When the power-up interval ends, the controller runs one dummy read. It holds `mem_cs_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` low with `mem_addr` at 0 for RD_CYC cycles. It raises no `rvalid`, and it acknowledges no request until the dummy read and the following one-cycle deselect are over.
- R3: A request seen in the idle state is answered with a one-cycle `ack` in the first cycle of the access. In that same cycle `mem_cs_n` is low.
- R4: A single read holds `mem_cs_n` and `mem_oe_n` low and `mem_we_n` high for RD_CYC cycles. During the read, `mem_lb_n` is the inverse of be[0] and `mem_ub_n` is the inverse of be[1]. `rvalid` is high in the cycle after the last one. In `rdata`, bits 7:0 come from the memory if be[0] is set and are 0 if it is not. Bits 15:8 follow be[1] in the same way.
- R5: A write holds `mem_cs_n` and `mem_we_n` low, `mem_oe_n` high and `mem_dq_oe` high for WR_CYC cycles. During the write, `mem_dq_o` equals `wdata` and the strobes follow be as in R4. With be = 0 no lane is written. The burst flag is ignored for writes.
- R6: A burst read starts at the address with bits 1:0 cleared and steps those bits through 0, 1, 2 and 3. Bits 20:2 do not change. `mem_cs_n` stays low for the whole burst. The first `rvalid` comes RD_CYC cycles after the access starts, and each of the other three comes PG_CYC cycles after the one before it.
- R7: After every access `mem_cs_n` goes high for at least one cycle before the next access begins. While it is high, all other memory controls are high as well.
- R8: `mem_dq_oe` is high only while `mem_we_n` is low. `mem_oe_n` never falls in the cycle right after `mem_dq_oe` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| be | input | 2 | Byte enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| addr | input | 21 | Word address |
| wdata | input | 16 | Write data |
| burst | input | 1 | Four-word page read |
| ack | output | 1 | Request accepted (one cycle) |
| rvalid | output | 1 | Read data valid (one cycle per word) |
| rdata | output | 16 | Read data, disabled lanes zero |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_addr | output | 21 | Memory address |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tristate enable for mem_dq_o |
| mem_dq_i | input | 16 | Data returned by the memory |

## Verification
The assertions check the pin rules on every cycle. They cover chip select held high during power-up, the write bus driven only under write enable, the bus released before output enable falls, the one-cycle `ack`, the deselect gap after each access, and the upper address staying fixed during a burst. The exact cycle counts, the order of the burst beats, lane masking and the writes landing in memory can only be shown by the bench. Its reference model predicts every pin and response on every clock for each scenario.

// File: rtl/psram_ctl.sv
module psram_ctl #(
  parameter int CLK_MHZ  = 250,
  parameter int PWRUP_US = 150,
  parameter int RD_CYC   = 18,
  parameter int PG_CYC   = 5,
  parameter int WR_CYC   = 18,
  parameter int AW       = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [1:0]    be,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  input  logic          burst,
  output logic          ack,
  output logic          rvalid,
  output logic [15:0]   rdata,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_i
);
  localparam int PWR_CYC = CLK_MHZ * PWRUP_US;
  localparam int CW      = $clog2(PWR_CYC + 1) + 1;

  typedef enum logic [2:0] {S_PWR, S_DUM, S_IDLE, S_RD, S_PG, S_WR, S_GAP} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [1:0]   beat;
  logic         burst_q;
  logic [1:0]   be_q;
  wire          done = (cnt == '0);
  wire  [15:0]  lane_mask = {{8{be_q[1]}}, {8{be_q[0]}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PWR;
      cnt       <= CW'(PWR_CYC - 1);
      beat      <= '0;
      burst_q   <= 1'b0;
      be_q      <= '0;
      ack       <= 1'b0;
      rvalid    <= 1'b0;
      rdata     <= '0;
      mem_cs_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      ack    <= 1'b0;
      rvalid <= 1'b0;
      case (st)
        S_PWR: begin
          if (done) begin
            st       <= S_DUM;
            cnt      <= CW'(RD_CYC - 1);
            mem_cs_n <= 1'b0;
            mem_oe_n <= 1'b0;
            mem_ub_n <= 1'b0;
            mem_lb_n <= 1'b0;
            mem_addr <= '0;
          end else cnt <= cnt - 1'b1;
        end
        S_DUM: begin
          if (done) begin
            st       <= S_GAP;
            mem_cs_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_ub_n <= 1'b1;
            mem_lb_n <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_IDLE: begin
          if (req) begin
            ack      <= 1'b1;
            be_q     <= be;
            burst_q  <= burst & ~we;
            beat     <= '0;
            mem_cs_n <= 1'b0;
            mem_ub_n <= ~be[1];
            mem_lb_n <= ~be[0];
            if (we) begin
              st        <= S_WR;
              cnt       <= CW'(WR_CYC - 1);
              mem_we_n  <= 1'b0;
              mem_dq_oe <= 1'b1;
              mem_dq_o  <= wdata;
              mem_addr  <= addr;
            end else begin
              st       <= S_RD;
              cnt      <= CW'(RD_CYC - 1);
              mem_oe_n <= 1'b0;
              mem_addr <= burst ? {addr[AW-1:2], 2'b00} : addr;
            end
          end
        end
        S_RD, S_PG: begin
          if (done) begin
            rvalid <= 1'b1;
            rdata  <= mem_dq_i & lane_mask;
            if (burst_q && beat != 2'd3) begin
              st            <= S_PG;
              beat          <= beat + 2'd1;
              mem_addr[1:0] <= mem_addr[1:0] + 2'd1;
              cnt           <= CW'(PG_CYC - 1);
            end else begin
              st       <= S_GAP;
              mem_cs_n <= 1'b1;
              mem_oe_n <= 1'b1;
              mem_ub_n <= 1'b1;
              mem_lb_n <= 1'b1;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_WR: begin
          if (done) begin
            st        <= S_GAP;
            mem_cs_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
          end else cnt <= cnt - 1'b1;
        end
        S_GAP:   st <= S_IDLE;
        default: st <= S_GAP;
      endcase
    end
  end

  p_pwr_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PWR) |-> (mem_cs_n && !ack && !rvalid));

  p_dummy_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DUM) |=> (!rvalid && !ack));

  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_ack_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !mem_cs_n);

  p_rvalid_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> $past(!mem_oe_n && mem_we_n));

  p_write_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && mem_oe_n && !mem_cs_n));

  p_page_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PG) |-> ($stable(mem_addr[AW-1:2]) && !mem_cs_n));

  p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |=> mem_cs_n);

  p_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n));

  p_dq_only_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));
endmodule

// File: tb/sim_psram_ctl.sv
`timescale 1ns/1ps
module sim_psram_ctl;
  localparam int CLKM = 250;
  localparam int PWUS = 150;
  localparam int RD   = 18;
  localparam int PG   = 5;
  localparam int WR   = 18;
  localparam int PWR  = CLKM * PWUS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, burst = 1'b0;
  logic [1:0] be = 2'b00;
  logic [20:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ack, rvalid, mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] rdata, mem_dq_o;
  logic [15:0] mem_dq_i = '0;
  logic [20:0] mem_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] pmem [int unsigned];
  logic [15:0] rmem [int unsigned];

  always #2 clk = ~clk;

  psram_ctl #(.CLK_MHZ(CLKM), .PWRUP_US(PWUS), .RD_CYC(RD), .PG_CYC(PG),
              .WR_CYC(WR), .AW(21)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .be(be), .addr(addr),
    .wdata(wdata), .burst(burst), .ack(ack), .rvalid(rvalid), .rdata(rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  function automatic logic [15:0] pget(input int unsigned a);
    return pmem.exists(a) ? pmem[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] rget(input int unsigned a);
    return rmem.exists(a) ? rmem[a] : 16'h0000;
  endfunction

  // pin-level memory: lanes not strobed read back as junk (stands for high-Z)
  always @(negedge clk) begin
    logic [15:0] w;
    w = pget(int'(mem_addr));
    if (!mem_cs_n && !mem_oe_n && mem_we_n)
      mem_dq_i <= {mem_ub_n ? 8'hA5 : w[15:8], mem_lb_n ? 8'hA5 : w[7:0]};
    else
      mem_dq_i <= 16'hA5A5;
  end

  always @(posedge clk) begin
    logic [15:0] w;
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
      w = pget(int'(mem_addr));
      if (!mem_lb_n) w[7:0] = mem_dq_o[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_o[15:8];
      pmem[int'(mem_addr)] = w;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R8 bus discipline, every clock
  logic prev_dq_oe = 1'b0, prev_oe_n = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 dq_oe only under we_n", {31'b0, mem_dq_oe & mem_we_n}, 0);
      chk("R8 release before oe", {31'b0, prev_oe_n & ~mem_oe_n & prev_dq_oe}, 0);
      prev_dq_oe <= mem_dq_oe;
      prev_oe_n  <= mem_oe_n;
    end
  end

  task automatic do_read(input logic [20:0] a, input logic [1:0] b, input bit br);
    int last_lo, tend, idx, bt;
    logic [20:0] ea;
    logic [15:0] w;
    last_lo = br ? RD + 3 * PG : RD;
    tend = last_lo + 1;
    req = 1'b1; we = 1'b0; be = b; addr = a; burst = br;
    for (int k = 1; k <= tend + 1; k++) begin
      @(negedge clk);
      if (k == 1) req = 1'b0;
      chk("R3 ack pulse", {31'b0, ack}, (k == 1) ? 1 : 0);
      if (k >= 1 && k <= last_lo) begin
        idx = (k <= RD) ? 0 : (k - RD - 1) / PG + 1;
        ea = br ? {a[20:2], 2'(idx)} : a;
        chk(br ? "R6 cs_n low in burst" : "R4 cs_n low", {31'b0, mem_cs_n}, 0);
        chk("R4 oe_n low", {31'b0, mem_oe_n}, 0);
        chk("R4 we_n high", {31'b0, mem_we_n}, 1);
        chk("R4 strobes", {30'b0, mem_ub_n, mem_lb_n}, {30'b0, ~b});
        chk(br ? "R6 page address" : "R4 address", {11'b0, mem_addr}, {11'b0, ea});
      end else begin
        chk("R7 deselect", {27'b0, mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 32'h1F);
      end
      bt = (k - RD - 1) / PG;
      if (k >= RD + 1 && (k - RD - 1) % PG == 0 && (br ? bt <= 3 : bt == 0)) begin
        chk(br ? "R6 rvalid beat" : "R4 rvalid", {31'b0, rvalid}, 1);
        ea = br ? {a[20:2], 2'(bt)} : a;
        w = rget(int'(ea));
        chk(br ? "R6 burst data" : "R4 rdata lanes", {16'b0, rdata},
            {16'b0, w & {{8{b[1]}}, {8{b[0]}}}});
      end else begin
        chk("R4 no rvalid", {31'b0, rvalid}, 0);
      end
    end
  endtask

  task automatic do_write(input logic [20:0] a, input logic [1:0] b,
                          input logic [15:0] d, input bit br);
    logic [15:0] w;
    req = 1'b1; we = 1'b1; be = b; addr = a; wdata = d; burst = br;
    for (int k = 1; k <= WR + 2; k++) begin
      @(negedge clk);
      if (k == 1) req = 1'b0;
      chk("R3 ack pulse", {31'b0, ack}, (k == 1) ? 1 : 0);
      chk("R5 no rvalid", {31'b0, rvalid}, 0);
      if (k <= WR) begin
        chk("R5 cs_n/we_n/oe_n", {29'b0, mem_cs_n, mem_we_n, mem_oe_n}, 32'h1);
        chk("R5 dq_oe", {31'b0, mem_dq_oe}, 1);
        chk("R5 dq_o", {16'b0, mem_dq_o}, {16'b0, d});
        chk("R5 address", {11'b0, mem_addr}, {11'b0, a});
        chk("R5 strobes", {30'b0, mem_ub_n, mem_lb_n}, {30'b0, ~b});
      end else begin
        chk("R7 deselect", {27'b0, mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 32'h1F);
        chk("R8 dq_oe released", {31'b0, mem_dq_oe}, 0);
      end
    end
    w = rget(int'(a));
    if (b[0]) w[7:0] = d[7:0];
    if (b[1]) w[15:8] = d[15:8];
    rmem[int'(a)] = w;
  endtask

  task automatic preload(input logic [20:0] a, input logic [15:0] d);
    pmem[int'(a)] = d;
    rmem[int'(a)] = d;
  endtask

  initial begin
    logic exp_cs;
    bit in_dummy;
    preload(21'h00040, 16'hBEEF);
    preload(21'h01234, 16'h1357);
    for (int i = 0; i < 4; i++) preload({19'h7FFFF, 2'(i)}, 16'hC000 + 16'(i * 16'h0101));
    for (int i = 0; i < 4; i++) preload({19'h00123, 2'(i)}, 16'h4000 + 16'(i * 16'h0011));

    repeat (3) @(negedge clk);
    chk("R1 reset controls", {27'b0, mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 32'h1F);
    chk("R1 reset ack/rvalid", {30'b0, ack, rvalid}, 0);
    rst_n = 1'b1;
    req = 1'b1; we = 1'b0; be = 2'b11; addr = 21'h00040; burst = 1'b0;
    for (int m = 1; m <= PWR + RD + 1; m++) begin
      @(negedge clk);
      in_dummy = (m >= PWR && m <= PWR + RD - 1);
      exp_cs = !in_dummy;
      chk(m < PWR ? "R1 cs_n high in power-up" : "R2 dummy cs_n", {31'b0, mem_cs_n}, {31'b0, exp_cs});
      chk("R2 request held off", {31'b0, ack}, 0);
      chk("R2 no rvalid for dummy", {31'b0, rvalid}, 0);
      if (in_dummy) begin
        chk("R2 dummy controls", {28'b0, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 32'h4);
        chk("R2 dummy address", {11'b0, mem_addr}, 0);
      end
    end
    do_read(21'h00040, 2'b11, 1'b0);
    do_read(21'h01234, 2'b11, 1'b0);
    do_read(21'h01234, 2'b01, 1'b0);
    do_read(21'h01234, 2'b10, 1'b0);
    do_write(21'h00077, 2'b11, 16'hA1B2, 1'b0);
    do_read(21'h00077, 2'b11, 1'b0);
    do_write(21'h00077, 2'b01, 16'hFFCC, 1'b0);
    do_write(21'h00077, 2'b10, 16'hDD00, 1'b0);
    do_write(21'h00077, 2'b00, 16'h0000, 1'b0);
    do_read(21'h00077, 2'b11, 1'b0);
    do_write(21'h00100, 2'b11, 16'h5A5A, 1'b1);
    do_read(21'h00100, 2'b11, 1'b0);
    do_read(21'h1FFFFE, 2'b11, 1'b1);
    do_read(21'h0048D, 2'b11, 1'b1);
    do_read(21'h0048C, 2'b01, 1'b1);
    do_write(21'h00101, 2'b10, 16'h7700, 1'b0);
    do_read(21'h00101, 2'b11, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule